// File: doc/BRIEF.md
# Pause Flow Control Unit

This block provides full-duplex pause flow control beside a 10/100 Ethernet MAC. On the receive side it inspects the incoming byte stream for a pause control frame. It extracts the 16-bit quanta value and runs a countdown measured in slot times, where one slot is 512 bit times. While the countdown runs, the `pause_active` output tells the data transmitter not to start a new data frame. A pause that arrives while a transmission is under way only takes hold once the line is quiet again. A matching frame also raises an early flag partway through, before the frame ends.

On the transmit side a request/acknowledge handshake launches a control frame. The frame is assembled byte by byte from configured destination, source, type, opcode and parameter fields and padded with zeros to the minimum length. It is started only after the interframe gap has elapsed. Control frames are not subject to the pause. Nibble serialization onto the media interface, CRC generation and host register access all sit outside this block.

Top module: `pfc_unit`

## Requirements
- R1: A received frame is recognized as a pause when all of the following hold. Byte indices 0..4 are 01,80,C2,00,00 and byte 5 lies in 01..0F. Bytes 12..13 (high byte first) equal `cfg_ctrl_type` and bytes 14..15 equal `cfg_pause_opcode`. At least 18 bytes arrived and `rx_crc_ok` is high in the `rx_eof` cycle. The quanta value is taken from bytes 16..17, high byte first.
- R2: `early_pause` goes high on the clock edge that takes in byte index 15 of a frame whose bytes 0..15 all match, and stays high until the edge that samples the next `rx_sof`.
- R3: With the line idle, `pause_active` rises on the edge that samples `rx_eof` of a pause frame with nonzero quanta Q. It stays high for exactly Q*SLOT_CYCLES clock cycles (SLOT_CYCLES defaults to 128).
- R4: If `mac_tx_busy` or `ctrl_inprog` is high when a nonzero pause is taken in, the load is deferred. It happens on the first edge at which both are sampled low.
- R5: A pause frame with quanta 0 clears `pause_active` on its `rx_eof` edge even while busy, and discards any deferred load.
- R6: A new nonzero pause frame reloads the countdown, replacing whatever time remained.
- R7: A frame that fails any part of R1 (address, type, opcode, CRC) leaves `pause_active` unchanged.
- R8: `ctrl_ack` is a single-cycle pulse answering a held `ctrl_req`. It fires on the (IFG_CYCLES+1)-th consecutive edge at which `mac_tx_busy` and `ctrl_inprog` are both sampled low (IFG_CYCLES defaults to 24), and never while either is high.
- R9: The control frame is presented on `ctrl_byte` in this order: `cfg_dst_addr` (6 bytes, bits 47:40 first), `cfg_src_addr` (6 bytes), `cfg_ctrl_type`, `cfg_pause_opcode` and `cfg_pause_param` (each high byte first), then zero bytes up to CTRL_LEN (default 60) bytes. The byte index advances only on edges where `ctrl_byte_take` is high.
- R10: `ctrl_inprog` rises with `ctrl_ack` and falls on the edge that takes the final byte.
- R11: A control frame is acknowledged and sent while `pause_active` is high, and sending it does not end the pause.
- R12: After reset `early_pause`, `pause_active`, `ctrl_ack` and `ctrl_inprog` are low, and the gap is treated as already elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Start of a received frame, one cycle before its first byte |
| rx_byte_valid | input | 1 | `rx_byte` carries a received byte |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End of the received frame |
| rx_crc_ok | input | 1 | Received frame CRC good, valid with `rx_eof` |
| mac_tx_busy | input | 1 | Data transmitter is sending a frame |
| cfg_ctrl_type | input | 16 | Control length/type value |
| cfg_pause_opcode | input | 16 | Pause opcode value |
| cfg_dst_addr | input | 48 | Destination address of sent control frames |
| cfg_src_addr | input | 48 | Source address of sent control frames |
| cfg_pause_param | input | 16 | Quanta placed in sent control frames |
| ctrl_req | input | 1 | Request to send a control frame, held until acknowledged |
| ctrl_byte_take | input | 1 | Downstream consumes the current control byte |
| early_pause | output | 1 | Pause frame recognized before its end |
| pause_active | output | 1 | Data frames must not start |
| ctrl_ack | output | 1 | Control send request accepted |
| ctrl_inprog | output | 1 | Control frame being sent |
| ctrl_byte | output | 8 | Current control frame byte |

## Verification
The bench times the pause to the exact cycle. A slot counter off by one, or a countdown that stops one slot early, would drop `pause_active` a cycle or a slot too soon. A pause arriving while the line is busy must stay invisible until the line clears, and a quanta-zero frame sent during that window must cancel the deferred load; a design that loaded immediately, or kept the stale pending value, would pause data frames that should be flowing. Addresses just outside the reserved range, a wrong type or opcode, and a bad CRC are each fed in to catch a matcher that checks too little. The control send is timed against the gap after a busy line and after its own frame. A design that ignored its own transmission when counting the gap would acknowledge back-to-back requests too early.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int BYTE_W   = 8;
    localparam int QUANTA_W = 16;
    localparam int RX_IDX_W = 5;

    // reserved multicast prefix of pause destinations (first five bytes)
    localparam logic [39:0] PAUSE_DA_PREFIX = 40'h01_80_C2_00_00;
    localparam logic [7:0]  PAUSE_DA_LAST_MAX = 8'h0F;

    // byte positions within a received control frame
    localparam int POS_DA_LAST = 5;
    localparam int POS_TYPE_HI = 12;
    localparam int POS_TYPE_LO = 13;
    localparam int POS_OP_HI   = 14;
    localparam int POS_OP_LO   = 15;
    localparam int POS_Q_HI    = 16;
    localparam int POS_Q_LO    = 17;
    localparam int MIN_PAUSE_BYTES = 18;

    typedef struct packed {
        logic [RX_IDX_W-1:0] idx;
        logic                match;
        logic [QUANTA_W-1:0] quanta;
        logic                early;
    } rx_state_t;
endpackage

// File: rtl/pfc_rx_parse.sv
module pfc_rx_parse
    import pfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_sof,
    input  logic                rx_byte_valid,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                rx_eof,
    input  logic                rx_crc_ok,
    input  logic [15:0]         cfg_ctrl_type,
    input  logic [15:0]         cfg_pause_opcode,
    output logic                pause_hit,
    output logic [QUANTA_W-1:0] pause_quanta,
    output logic                early_pause
);
    localparam logic [RX_IDX_W-1:0] IDX_MAX = '1;

    rx_state_t st_d, st_q;
    logic      byte_ok;

    always_comb begin
        unique case (int'(st_q.idx))
            0:           byte_ok = (rx_byte == PAUSE_DA_PREFIX[39:32]);
            1:           byte_ok = (rx_byte == PAUSE_DA_PREFIX[31:24]);
            2:           byte_ok = (rx_byte == PAUSE_DA_PREFIX[23:16]);
            3:           byte_ok = (rx_byte == PAUSE_DA_PREFIX[15:8]);
            4:           byte_ok = (rx_byte == PAUSE_DA_PREFIX[7:0]);
            POS_DA_LAST: byte_ok = (rx_byte != '0) && (rx_byte <= PAUSE_DA_LAST_MAX);
            POS_TYPE_HI: byte_ok = (rx_byte == cfg_ctrl_type[15:8]);
            POS_TYPE_LO: byte_ok = (rx_byte == cfg_ctrl_type[7:0]);
            POS_OP_HI:   byte_ok = (rx_byte == cfg_pause_opcode[15:8]);
            POS_OP_LO:   byte_ok = (rx_byte == cfg_pause_opcode[7:0]);
            default:     byte_ok = 1'b1;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rx_sof) begin
            st_d.idx    = '0;
            st_d.match  = 1'b1;
            st_d.early  = 1'b0;
            st_d.quanta = '0;
        end else if (rx_byte_valid) begin
            st_d.match = st_q.match & byte_ok;
            if (int'(st_q.idx) == POS_Q_HI) st_d.quanta[15:8] = rx_byte;
            if (int'(st_q.idx) == POS_Q_LO) st_d.quanta[7:0]  = rx_byte;
            if (int'(st_q.idx) == POS_OP_LO && st_q.match && byte_ok) st_d.early = 1'b1;
            if (st_q.idx != IDX_MAX) st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: IDX_MAX, match: 1'b0, quanta: '0, early: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pause_hit    = rx_eof & rx_crc_ok & st_q.match & (int'(st_q.idx) >= MIN_PAUSE_BYTES);
    assign pause_quanta = st_q.quanta;
    assign early_pause  = st_q.early;
endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer
    import pfc_pkg::*;
#(
    parameter int SLOT_CYCLES = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pause_hit,
    input  logic [QUANTA_W-1:0] pause_quanta,
    input  logic                line_busy,
    output logic                pause_active
);
    localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);

    typedef struct packed {
        logic                active;
        logic [QUANTA_W-1:0] remain;
        logic [SLOT_W-1:0]   slot;
        logic                pend_v;
        logic [QUANTA_W-1:0] pend_q;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // slot counting and countdown
        if (st_q.active) begin
            if (st_q.slot == SLOT_LAST) begin
                st_d.slot = '0;
                if (st_q.remain == QUANTA_W'(1)) begin
                    st_d.active = 1'b0;
                    st_d.remain = '0;
                end else begin
                    st_d.remain = st_q.remain - 1'b1;
                end
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
        // deferred load once the line is quiet
        if (st_q.pend_v && !line_busy) begin
            st_d.active = 1'b1;
            st_d.remain = st_q.pend_q;
            st_d.slot   = '0;
            st_d.pend_v = 1'b0;
        end
        // newly received pause frame
        if (pause_hit) begin
            if (pause_quanta == '0) begin
                st_d.active = 1'b0;
                st_d.remain = '0;
                st_d.slot   = '0;
                st_d.pend_v = 1'b0;
            end else if (line_busy) begin
                st_d.pend_v = 1'b1;
                st_d.pend_q = pause_quanta;
            end else begin
                st_d.active = 1'b1;
                st_d.remain = pause_quanta;
                st_d.slot   = '0;
                st_d.pend_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pause_active = st_q.active;
endmodule

// File: rtl/pfc_ctrl_tx.sv
module pfc_ctrl_tx
    import pfc_pkg::*;
#(
    parameter int IFG_CYCLES = 24,
    parameter int CTRL_LEN   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_tx_busy,
    input  logic              ctrl_req,
    input  logic              ctrl_byte_take,
    input  logic [47:0]       cfg_dst_addr,
    input  logic [47:0]       cfg_src_addr,
    input  logic [15:0]       cfg_ctrl_type,
    input  logic [15:0]       cfg_pause_opcode,
    input  logic [15:0]       cfg_pause_param,
    output logic              ctrl_ack,
    output logic              ctrl_inprog,
    output logic [BYTE_W-1:0] ctrl_byte
);
    localparam int IDX_W = $clog2(CTRL_LEN);
    localparam int GAP_W = $clog2(IFG_CYCLES + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CTRL_LEN - 1);
    localparam logic [GAP_W-1:0] GAP_DONE = GAP_W'(IFG_CYCLES);

    typedef struct packed {
        logic             inprog;
        logic             ack;
        logic [IDX_W-1:0] idx;
        logic [GAP_W-1:0] gap;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       start;
    int         bi;

    assign start = ctrl_req && !st_q.inprog && !mac_tx_busy && (st_q.gap == GAP_DONE);

    always_comb begin
        st_d     = st_q;
        st_d.ack = start;
        if (mac_tx_busy || st_q.inprog) begin
            st_d.gap = '0;
        end else if (st_q.gap != GAP_DONE) begin
            st_d.gap = st_q.gap + 1'b1;
        end
        if (start) begin
            st_d.inprog = 1'b1;
            st_d.idx    = '0;
        end else if (st_q.inprog && ctrl_byte_take) begin
            if (st_q.idx == IDX_LAST) begin
                st_d.inprog = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_comb begin
        bi = int'(st_q.idx);
        if (bi < 6) begin
            ctrl_byte = cfg_dst_addr[8*(5-bi) +: 8];
        end else if (bi < 12) begin
            ctrl_byte = cfg_src_addr[8*(11-bi) +: 8];
        end else begin
            unique case (bi)
                POS_TYPE_HI: ctrl_byte = cfg_ctrl_type[15:8];
                POS_TYPE_LO: ctrl_byte = cfg_ctrl_type[7:0];
                POS_OP_HI:   ctrl_byte = cfg_pause_opcode[15:8];
                POS_OP_LO:   ctrl_byte = cfg_pause_opcode[7:0];
                POS_Q_HI:    ctrl_byte = cfg_pause_param[15:8];
                POS_Q_LO:    ctrl_byte = cfg_pause_param[7:0];
                default:     ctrl_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{inprog: 1'b0, ack: 1'b0, idx: '0, gap: GAP_DONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_ack    = st_q.ack;
    assign ctrl_inprog = st_q.inprog;
endmodule

// File: rtl/pfc_unit.sv
module pfc_unit
    import pfc_pkg::*;
#(
    parameter int SLOT_CYCLES = 128,
    parameter int IFG_CYCLES  = 24,
    parameter int CTRL_LEN    = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_byte_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eof,
    input  logic        rx_crc_ok,
    input  logic        mac_tx_busy,
    input  logic [15:0] cfg_ctrl_type,
    input  logic [15:0] cfg_pause_opcode,
    input  logic [47:0] cfg_dst_addr,
    input  logic [47:0] cfg_src_addr,
    input  logic [15:0] cfg_pause_param,
    input  logic        ctrl_req,
    input  logic        ctrl_byte_take,
    output logic        early_pause,
    output logic        pause_active,
    output logic        ctrl_ack,
    output logic        ctrl_inprog,
    output logic [7:0]  ctrl_byte
);
    logic                hit;
    logic [QUANTA_W-1:0] quanta;
    logic                line_busy;

    assign line_busy = mac_tx_busy | ctrl_inprog;

    pfc_rx_parse u_rx (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_sof           (rx_sof),
        .rx_byte_valid    (rx_byte_valid),
        .rx_byte          (rx_byte),
        .rx_eof           (rx_eof),
        .rx_crc_ok        (rx_crc_ok),
        .cfg_ctrl_type    (cfg_ctrl_type),
        .cfg_pause_opcode (cfg_pause_opcode),
        .pause_hit        (hit),
        .pause_quanta     (quanta),
        .early_pause      (early_pause)
    );

    pfc_pause_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .pause_hit    (hit),
        .pause_quanta (quanta),
        .line_busy    (line_busy),
        .pause_active (pause_active)
    );

    pfc_ctrl_tx #(.IFG_CYCLES(IFG_CYCLES), .CTRL_LEN(CTRL_LEN)) u_ctl (
        .clk              (clk),
        .rst_n            (rst_n),
        .mac_tx_busy      (mac_tx_busy),
        .ctrl_req         (ctrl_req),
        .ctrl_byte_take   (ctrl_byte_take),
        .cfg_dst_addr     (cfg_dst_addr),
        .cfg_src_addr     (cfg_src_addr),
        .cfg_ctrl_type    (cfg_ctrl_type),
        .cfg_pause_opcode (cfg_pause_opcode),
        .cfg_pause_param  (cfg_pause_param),
        .ctrl_ack         (ctrl_ack),
        .ctrl_inprog      (ctrl_inprog),
        .ctrl_byte        (ctrl_byte)
    );
endmodule

// File: rtl/pfc_unit_chk.sv
module pfc_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_sof,
    input logic mac_tx_busy,
    input logic ctrl_req,
    input logic ctrl_byte_take,
    input logic early_pause,
    input logic pause_active,
    input logic ctrl_ack,
    input logic ctrl_inprog
);
    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ack |=> !ctrl_ack);

    a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_ack) |-> $past(ctrl_req));

    a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_inprog) |-> !$past(mac_tx_busy));

    a_r10_ack_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ack |-> ctrl_inprog);

    a_r10_end_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_inprog) |-> $past(ctrl_byte_take));

    a_r4_no_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_active) |-> (!$past(mac_tx_busy) && !$past(ctrl_inprog)));

    a_r2_early_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(early_pause) |-> $past(rx_sof));
endmodule

bind pfc_unit pfc_unit_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_sof         (rx_sof),
    .mac_tx_busy    (mac_tx_busy),
    .ctrl_req       (ctrl_req),
    .ctrl_byte_take (ctrl_byte_take),
    .early_pause    (early_pause),
    .pause_active   (pause_active),
    .ctrl_ack       (ctrl_ack),
    .ctrl_inprog    (ctrl_inprog)
);

// File: tb/pfc_unit_tb_top.sv
`timescale 1ns/1ps
module pfc_unit_tb_top;
    localparam int SLOT = 128;
    localparam int IFG  = 24;
    localparam int LEN  = 60;

    localparam logic [15:0] T_TYPE = 16'h8808;
    localparam logic [15:0] T_OP   = 16'h0001;
    localparam logic [47:0] T_DA   = 48'h0180C2000001;
    localparam logic [47:0] T_SA   = 48'h02AABBCCDDEE;
    localparam logic [15:0] T_PRM  = 16'h1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sof = 0, rx_byte_valid = 0, rx_eof = 0, rx_crc_ok = 0;
    logic [7:0] rx_byte = '0;
    logic mac_tx_busy = 0, ctrl_req = 0, ctrl_byte_take = 0;
    logic early_pause, pause_active, ctrl_ack, ctrl_inprog;
    logic [7:0] ctrl_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_byte_valid(rx_byte_valid),
        .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
        .mac_tx_busy(mac_tx_busy), .cfg_ctrl_type(T_TYPE), .cfg_pause_opcode(T_OP),
        .cfg_dst_addr(T_DA), .cfg_src_addr(T_SA), .cfg_pause_param(T_PRM),
        .ctrl_req(ctrl_req), .ctrl_byte_take(ctrl_byte_take),
        .early_pause(early_pause), .pause_active(pause_active), .ctrl_ack(ctrl_ack),
        .ctrl_inprog(ctrl_inprog), .ctrl_byte(ctrl_byte)
    );

    typedef struct packed {
        logic [7:0]  da5;
        logic [15:0] typ;
        logic [15:0] op;
        logic [15:0] q;
        logic        crc;
        logic        exp_early;
        logic        exp_active;
    } vec_t;

    // R1 / R7 vectors: address range edges, type, opcode, CRC
    localparam vec_t VECS [7] = '{
        '{8'h01, T_TYPE, T_OP,    16'd2, 1'b1, 1'b1, 1'b1},
        '{8'h0F, T_TYPE, T_OP,    16'd1, 1'b1, 1'b1, 1'b1},
        '{8'h10, T_TYPE, T_OP,    16'd2, 1'b1, 1'b0, 1'b0},
        '{8'h01, 16'h0800, T_OP,  16'd2, 1'b1, 1'b0, 1'b0},
        '{8'h01, T_TYPE, 16'h0002,16'd2, 1'b1, 1'b0, 1'b0},
        '{8'h01, T_TYPE, T_OP,    16'd2, 1'b0, 1'b1, 1'b0},
        '{8'h00, T_TYPE, T_OP,    16'd2, 1'b1, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] da5, input logic [15:0] typ,
                              input logic [15:0] op, input logic [15:0] q,
                              input logic crc, output logic e14, output logic e15);
        logic [7:0] fr [20];
        fr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, da5,
               8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
               typ[15:8], typ[7:0], op[15:8], op[7:0], q[15:8], q[7:0], 8'h00, 8'h00};
        rx_sof = 1;
        tick();
        rx_sof = 0;
        for (int i = 0; i < 20; i++) begin
            rx_byte_valid = 1;
            rx_byte = fr[i];
            tick();
            if (i == 14) e14 = early_pause;
            if (i == 15) e15 = early_pause;
        end
        rx_byte_valid = 0;
        rx_eof = 1;
        rx_crc_ok = crc;
        tick();
        rx_eof = 0;
        rx_crc_ok = 0;
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        logic [143:0] hdr;
        hdr = {T_DA, T_SA, T_TYPE, T_OP, T_PRM};
        return (i < 18) ? hdr[143 - 8*i -: 8] : 8'h00;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic e14, e15;
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check("R12 early", int'(early_pause), 0);
        check("R12 active", int'(pause_active), 0);
        check("R12 ack", int'(ctrl_ack), 0);
        check("R12 inprog", int'(ctrl_inprog), 0);
        rst_n = 1;
        tick();

        // vector table: R1, R2, R7
        for (int v = 0; v < 7; v++) begin
            send_frame(VECS[v].da5, VECS[v].typ, VECS[v].op, VECS[v].q, VECS[v].crc, e14, e15);
            check("R2 early before byte 15", int'(e14), 0);
            check("R2 early at byte 15", int'(e15), int'(VECS[v].exp_early));
            check("R1 R7 pause after frame", int'(pause_active), int'(VECS[v].exp_active));
            check("R2 early held to eof", int'(early_pause), int'(VECS[v].exp_early));
            send_frame(8'h01, T_TYPE, T_OP, 16'd0, 1'b1, e14, e15);
            check("R5 zero quanta clears", int'(pause_active), 0);
        end

        // R3 exact duration, Q=3
        send_frame(8'h01, T_TYPE, T_OP, 16'd3, 1'b1, e14, e15);
        check("R3 rises at eof", int'(pause_active), 1);
        repeat (3*SLOT - 1) tick();
        check("R3 still active at last cycle", int'(pause_active), 1);
        tick();
        check("R3 ends after Q slots", int'(pause_active), 0);

        // R6 reload with shorter value
        send_frame(8'h01, T_TYPE, T_OP, 16'd2, 1'b1, e14, e15);
        repeat (100) tick();
        send_frame(8'h01, T_TYPE, T_OP, 16'd1, 1'b1, e14, e15);
        check("R6 active after reload", int'(pause_active), 1);
        repeat (SLOT - 1) tick();
        check("R6 reloaded last cycle", int'(pause_active), 1);
        tick();
        check("R6 reload replaced remainder", int'(pause_active), 0);

        // R4 deferred while busy
        mac_tx_busy = 1;
        send_frame(8'h01, T_TYPE, T_OP, 16'd2, 1'b1, e14, e15);
        check("R4 held off while busy", int'(pause_active), 0);
        repeat (5) tick();
        check("R4 still held off", int'(pause_active), 0);
        mac_tx_busy = 0;
        tick();
        check("R4 loads when idle", int'(pause_active), 1);

        // R5 zero quanta while busy, and cancel pending
        mac_tx_busy = 1;
        send_frame(8'h01, T_TYPE, T_OP, 16'd0, 1'b1, e14, e15);
        check("R5 zero clears while busy", int'(pause_active), 0);
        send_frame(8'h01, T_TYPE, T_OP, 16'd2, 1'b1, e14, e15);
        send_frame(8'h01, T_TYPE, T_OP, 16'd0, 1'b1, e14, e15);
        mac_tx_busy = 0;
        repeat (3) tick();
        check("R5 pending discarded", int'(pause_active), 0);

        // R8 gap after busy line
        mac_tx_busy = 1;
        ctrl_req = 1;
        repeat (3) tick();
        check("R8 no ack while busy", int'(ctrl_ack), 0);
        mac_tx_busy = 0;
        repeat (IFG) tick();
        check("R8 no ack before gap", int'(ctrl_inprog), 0);
        tick();
        check("R8 ack after gap", int'(ctrl_ack), 1);
        check("R10 inprog with ack", int'(ctrl_inprog), 1);
        ctrl_req = 0;
        tick();
        check("R8 ack single cycle", int'(ctrl_ack), 0);
        check("R9 stall holds byte", int'(ctrl_byte), int'(exp_byte(0)));

        // R9 / R10 byte stream
        ctrl_req = 1;
        for (int i = 0; i < LEN; i++) begin
            check("R9 byte", int'(ctrl_byte), int'(exp_byte(i)));
            check("R10 inprog during frame", int'(ctrl_inprog), 1);
            ctrl_byte_take = 1;
            tick();
        end
        ctrl_byte_take = 0;
        check("R10 inprog ends after last take", int'(ctrl_inprog), 0);
        // R8 back-to-back: gap counted from own frame end
        repeat (IFG) tick();
        check("R8 no ack within own gap", int'(ctrl_ack), 0);
        tick();
        check("R8 ack after own gap", int'(ctrl_ack), 1);
        ctrl_req = 0;
        ctrl_byte_take = 1;
        repeat (LEN) tick();
        ctrl_byte_take = 0;
        check("R10 second frame ended", int'(ctrl_inprog), 0);

        // R11 control send while paused
        repeat (30) tick();
        send_frame(8'h01, T_TYPE, T_OP, 16'd3, 1'b1, e14, e15);
        check("R11 paused", int'(pause_active), 1);
        ctrl_req = 1;
        tick();
        check("R11 ack while paused", int'(ctrl_ack), 1);
        check("R11 pause kept", int'(pause_active), 1);
        ctrl_req = 0;
        ctrl_byte_take = 1;
        repeat (LEN) tick();
        ctrl_byte_take = 0;
        check("R11 pause survives frame", int'(pause_active), 1);

        finish_run();
    end
endmodule